// File: doc/BRIEF.md
# Interleaved Two-Channel Peak-Current Chopper

This block produces the switch enables for two stepper-motor channels that regulate winding current by fixed-frequency peak-current chopping. One digital timebase ticks at twice the chopping rate. Each tick goes to the two channels in turn, so channel A and channel B begin their on-times half a chopping period apart. This keeps the two supply current peaks from lining up.

In each channel a tick sets an on-latch, and the latch enables the high-side switch. An external current comparator feeds a digital over-current input that clears the latch. For a programmable number of clocks after each tick, the latch ignores that input, which blanks the switching spike. While the high side is off, the channel's low-side switches are enabled to carry recirculation current. The tick spacing and the blanking length are parameters counted in system clocks. The default values give about 41 kHz ticks and a 1.4 µs blanking window from a 100 MHz clock.

Top module: `chop_dual_ctrl`

## Requirements
- R1: The timebase issues one tick every TICK_CYCLES clocks. Ticks go to channel A (bit 0) and channel B (bit 1) in strict alternation. The first tick after reset release goes to channel A, at clock edge TICK_CYCLES.
- R2: A channel's high-side enable rises on the clock edge after its tick. Measured from reset release, this is edge TICK_CYCLES+1 for channel A and edge 2*TICK_CYCLES+1 for channel B. After that it repeats every 2*TICK_CYCLES clocks.
- R3: An over-current input that is sampled high after blanking has ended clears the high-side enable at that same clock edge. The enable then stays low until the channel's next tick.
- R4: For LOCK_CYCLES clock edges after the edge that set the latch, the over-current input has no effect. With a trip first sampled at offset d from the set edge, the on-time is max(d, LOCK_CYCLES+1) clocks.
- R5: With LOCK_CYCLES = 0 there is no blanking. A trip sampled at offset d gives an on-time of exactly d clocks.
- R6: If the over-current input is already high when a tick arrives, the tick still sets the latch. The latch is then cleared at the first sample after blanking, giving an on-time of LOCK_CYCLES+1 clocks.
- R7: A tick that arrives while the latch is set keeps the high side on without a gap. Without trips, the high-side enable stays high from its first tick onward.
- R8: From the first clock after reset release, each channel's low-side enable is the complement of its high-side enable. The two are never high together.
- R9: An active-low reset immediately forces all high-side and low-side enables low. It holds them low until the reset is released.
- R10: The two channels are independent. The over-current input of one channel never changes the enables of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trip_i | input | 2 | Over-current comparator result, bit 0 channel A, bit 1 channel B |
| hs_on_o | output | 2 | High-side switch enable per channel |
| ls_on_o | output | 2 | Low-side recirculation enable per channel |

## Verification
Each run holds each channel's over-current input low until a chosen offset d after that channel's set edge. The input then stays high through the next tick. Sweeping d from 1, which means tripped at the tick itself, through values inside the blanking window, at its edge and past it, up to beyond the period, separates four behaviours: blanked trips, immediate trips, trips held across a tick, and free-running on-time. The two channels get different d in the same run, so crosstalk and swapped phases show up. A second instance with blanking disabled, fed the same inputs, separates the counted window from plain sampling.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int NCH = 2;
  typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/chop_timebase.sv
module chop_timebase
  import chop_pkg::*;
#(
  parameter int TICK_CYCLES = 2439
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  output ch_vec_t sync_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  ch_vec_t       sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      sync_q  <= '0;
    end else begin
      sync_q <= '0;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
        sync_q  <= phase_q ? 2'b10 : 2'b01;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sync_o = sync_q;

  // alternation tracker for checks only
  logic seen_a_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_a_q <= 1'b0;
    else if (sync_q[0]) seen_a_q <= 1'b1;
    else if (sync_q[1]) seen_a_q <= 1'b0;
  end

  p_sync_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sync_q));
  p_sync_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q != '0) |=> (sync_q == '0));
  p_sync_alt_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q[0] |-> !seen_a_q);
  p_sync_alt_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q[1] |-> seen_a_q);
endmodule

// File: rtl/chop_channel.sv
module chop_channel #(
  parameter int LOCK_CYCLES = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic trip_i,
  output logic hs_on_o,
  output logic ls_on_o
);
  logic on_q, on_d, ls_q, blank;

  generate
    if (LOCK_CYCLES > 0) begin : g_lock
      localparam int LW = $clog2(LOCK_CYCLES + 1);
      logic [LW-1:0] lock_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            lock_q <= '0;
        else if (sync_i)        lock_q <= LW'(LOCK_CYCLES);
        else if (lock_q != '0)  lock_q <= lock_q - 1'b1;
      end
      assign blank = (lock_q != '0);
    end else begin : g_nolock
      assign blank = 1'b0;
    end
  endgenerate

  // tick wins over a trip in the same cycle
  always_comb begin
    if (sync_i) on_d = 1'b1;
    else        on_d = on_q && !(trip_i && !blank);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      on_q <= on_d;
      ls_q <= ~on_d;
    end
  end

  assign hs_on_o = on_q;
  assign ls_on_o = ls_q;

  p_set_on_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> on_q);
  p_blank_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && blank && !sync_i) |=> on_q);
  p_trip_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && !blank && trip_i && !sync_i) |=> !on_q);
  p_off_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q && !sync_i) |=> !on_q);
  p_hs_ls_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> !ls_q);
endmodule

// File: rtl/chop_dual_ctrl.sv
module chop_dual_ctrl
  import chop_pkg::*;
#(
  parameter int TICK_CYCLES = 2439,
  parameter int LOCK_CYCLES = 140
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  trip_i,
  output logic [NCH-1:0]  hs_on_o,
  output logic [NCH-1:0]  ls_on_o
);
  ch_vec_t sync;

  chop_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_o (sync)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chop_channel #(.LOCK_CYCLES(LOCK_CYCLES)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[c]),
      .trip_i  (trip_i[c]),
      .hs_on_o (hs_on_o[c]),
      .ls_on_o (ls_on_o[c])
    );
  end

  p_reset_off_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (hs_on_o == '0 && ls_on_o == '0));
  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sync) |-> $countones(hs_on_o & ~$past(hs_on_o)) <= 1);
endmodule

// File: tb/chop_dual_ctrl_test.sv
`timescale 1ns/1ps
module chop_dual_ctrl_test;
  localparam int TICK = 20;
  localparam int LOCK = 4;
  localparam int PER  = 2 * TICK;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] trip = 2'b00;
  logic [1:0] hs, ls, hs0, ls0;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chop_dual_ctrl #(.TICK_CYCLES(TICK), .LOCK_CYCLES(LOCK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .trip_i(trip), .hs_on_o(hs), .ls_on_o(ls));
  chop_dual_ctrl #(.TICK_CYCLES(TICK), .LOCK_CYCLES(0)) uut_nolock (
    .clk_i(clk), .rst_ni(rst_ni), .trip_i(trip), .hs_on_o(hs0), .ls_on_o(ls0));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // on-time k = max(d, lock+1) counted from the set edge (R4, R5, R6)
  function automatic bit exp_hs(int n, int start, int d, int lk);
    int off, k;
    if (n < start) return 1'b0;
    off = (n - start) % PER;
    k = (d > lk + 1) ? d : lk + 1;
    return off < k;
  endfunction

  // trip high from offset d (as sampled) until the next tick
  function automatic bit trip_drv(int n, int start, int d);
    if (n < start) return 1'b0;
    return ((n - start) % PER) >= d - 1;
  endfunction

  task automatic run(int da, int db, string tag);
    logic [1:0] eh, eh0;
    int n;
    @(negedge clk);
    #0.5 rst_ni = 1'b0;
    #0.2;
    chk(hs == 2'b00 && hs0 == 2'b00, "R9", "hs async reset", {hs0, hs}, 0);
    chk(ls == 2'b00 && ls0 == 2'b00, "R9", "ls async reset", {ls0, ls}, 0);
    trip = 2'b00;
    repeat (3) @(negedge clk);
    chk(hs == 2'b00 && ls == 2'b00, "R9", "held in reset", {ls, hs}, 0);
    rst_ni = 1'b1;
    n = 0;
    for (int c = 0; c < 3 * PER; c++) begin
      @(negedge clk);
      n++;
      // channel A sets at edge TICK+1, channel B at 2*TICK+1 (R1, R2)
      eh  = {exp_hs(n, 2*TICK+1, db, LOCK), exp_hs(n, TICK+1, da, LOCK)};
      eh0 = {exp_hs(n, 2*TICK+1, db, 0),    exp_hs(n, TICK+1, da, 0)};
      chk(hs == eh, tag, $sformatf("hs n=%0d da=%0d db=%0d", n, da, db), hs, eh);
      chk(hs0 == eh0, tag, $sformatf("hs nolock n=%0d", n), hs0, eh0);
      chk(ls == ~eh, "R8", $sformatf("ls n=%0d", n), ls, ~eh);
      chk(ls0 == ~eh0, "R8", $sformatf("ls nolock n=%0d", n), ls0, ~eh0);
      trip = {trip_drv(n, 2*TICK+1, db), trip_drv(n, TICK+1, da)};
    end
  endtask

  initial begin
    #1;
    chk(hs == 2'b00 && ls == 2'b00, "R9", "initial reset state", {ls, hs}, 0);
    run(1, 7, "R6 R2");     // trip held across ticks: on-time LOCK+1
    run(2, 3, "R4 R5");     // early trips blanked; nolock instance cuts short
    run(5, 6, "R3 R10");    // trips right at and after window end
    run(4, 41, "R4 R7");    // B never trips: stays on
    run(10, 1, "R3 R6");
    run(39, 5, "R1 R3");    // trip one clock before next tick
    run(41, 41, "R1 R7");   // free running, phase alternation visible
    run(6, 2, "R10 R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule